// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Cell

This block is a configurable logic cell built around one 64-bit truth table. It has eight data inputs: four shared inputs (a, b, c, d) and two private pairs, (e0, f0) for the first result and (e1, f1) for the second. A three-bit layout code chooses how the table is read. The table can act as one six-input function, or it can be split into two smaller functions that follow fixed rules for which inputs they share. The two results drive `out0` and `out1`. Each result can go straight to its pin or pass through an output register first.

The table, the layout code and the two bypass bits are loaded serially through a single data pin while a load strobe is high. The new setting takes effect once the strobe drops. While the strobe is high, both outputs read 0. A host loads the setting once and then drives the data inputs. In registered operation, a shared clock enable controls when the output registers capture.

Top module: `frac_lut_cell`

## Requirements
- R1: The setting chain is 69 bits long and is shifted in on rising edges while `cfg_load` is high. The order is: table bit 63 first down to table bit 0, then layout code bit 2 down to bit 0, then the bypass bit for `out0`, then the bypass bit for `out1`. The loaded setting applies once `cfg_load` is low.
- R2: While `cfg_load` is high, `out0` and `out1` are both 0.
- R3: Table index bit 0 is a, bit 1 is b, bit 2 is c and bit 3 is d. With code 0, `out0` = T[{f0,e0,d,c,b,a}] and `out1` = 0. With code 1, `out1` = T[{f1,e1,d,c,b,a}] and `out0` = 0.
- R4: Code 2 gives two independent four-input functions. `out0` = T[{2'b00,f0,e0,b,a}] and `out1` = T[{2'b10,f1,e1,d,c}]. No input is shared between them.
- R5: Code 3 gives a five-input function and an independent three-input function. `out0` = T[{1'b0,f0,e0,c,b,a}] and `out1` = T[{3'b100,f1,e1,d}]. No input is shared between them.
- R6: Code 4 gives two five-input functions that share a and b. `out0` = T[{1'b0,f0,e0,c,b,a}] and `out1` = T[{1'b1,f1,e1,d,b,a}]. A four-input partner that shares only one of a or b fits this code when its table half ignores the other shared input.
- R7: Code 5 gives two six-input functions from the same table. `out0` = T[{f0,e0,d,c,b,a}] and `out1` = T[{f1,e1,d,c,b,a}]. With a suitable table, this realises a 4x2 crossbar: each output selects one of a..d using its own private pair as the 2-bit select.
- R8: Codes 6 and 7 are unsupported and force both outputs to 0.
- R9: A bypass bit of 1 sends that result to its pin in the same cycle. A bypass bit of 0 shows the value the output register captured on the last rising edge where `ce` was high.
- R10: While `ce` is low, the output registers hold their value. A synchronous high `rst` clears the output registers and the whole setting chain to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Load strobe for the serial setting chain |
| cfg_bit | input | 1 | Serial setting data |
| ce | input | 1 | Shared capture enable for both output registers |
| in_a | input | 1 | Shared input a |
| in_b | input | 1 | Shared input b |
| in_c | input | 1 | Shared input c |
| in_d | input | 1 | Shared input d |
| in_e0 | input | 1 | Private input e of result 0 |
| in_f0 | input | 1 | Private input f of result 0 |
| in_e1 | input | 1 | Private input e of result 1 |
| in_f1 | input | 1 | Private input f of result 1 |
| out0 | output | 1 | Result 0 |
| out1 | output | 1 | Result 1 |

## Verification
With a bypass bit set, a result is due in the same cycle as the input change. The bench drives inputs on the falling edge and compares a quarter period later, before the next rising edge. With the bypass bit clear, a result is due one rising edge after capture. Those checks wait for that edge and sample a quarter period after it. A loaded setting counts from the first falling edge after the 69th shift edge. Outputs are also sampled during shifting to confirm they stay at 0.

// File: rtl/flc_pkg.sv
package flc_pkg;

  localparam int LUT_INPUTS = 6;
  localparam int TBL_W      = 1 << LUT_INPUTS;
  localparam int CODE_W     = 3;
  localparam int NUM_RES    = 2;
  localparam int CHAIN_W    = TBL_W + CODE_W + NUM_RES;

  localparam logic [CODE_W-1:0] LAY_SIX_LO    = 3'd0;
  localparam logic [CODE_W-1:0] LAY_SIX_HI    = 3'd1;
  localparam logic [CODE_W-1:0] LAY_QUAD_PAIR = 3'd2;
  localparam logic [CODE_W-1:0] LAY_FIVE_THR  = 3'd3;
  localparam logic [CODE_W-1:0] LAY_FIVE_FIVE = 3'd4;
  localparam logic [CODE_W-1:0] LAY_SIX_SHARE = 3'd5;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
    logic e0;
    logic f0;
    logic e1;
    logic f1;
  } cell_in_t;

  typedef struct packed {
    logic                  hit;
    logic [LUT_INPUTS-1:0] idx;
  } tap_t;

  // Table index for one result; hit=0 means that result is forced low.
  function automatic tap_t result_tap(input logic [CODE_W-1:0] code,
                                      input cell_in_t x,
                                      input logic res);
    tap_t t;
    t = '0;
    case (code)
      LAY_SIX_LO: if (!res) t = '{1'b1, {x.f0, x.e0, x.d, x.c, x.b, x.a}};
      LAY_SIX_HI: if (res)  t = '{1'b1, {x.f1, x.e1, x.d, x.c, x.b, x.a}};
      LAY_QUAD_PAIR:
        t = res ? '{1'b1, {2'b10, x.f1, x.e1, x.d, x.c}}
                : '{1'b1, {2'b00, x.f0, x.e0, x.b, x.a}};
      LAY_FIVE_THR:
        t = res ? '{1'b1, {3'b100, x.f1, x.e1, x.d}}
                : '{1'b1, {1'b0, x.f0, x.e0, x.c, x.b, x.a}};
      LAY_FIVE_FIVE:
        t = res ? '{1'b1, {1'b1, x.f1, x.e1, x.d, x.b, x.a}}
                : '{1'b1, {1'b0, x.f0, x.e0, x.c, x.b, x.a}};
      LAY_SIX_SHARE:
        t = res ? '{1'b1, {x.f1, x.e1, x.d, x.c, x.b, x.a}}
                : '{1'b1, {x.f0, x.e0, x.d, x.c, x.b, x.a}};
      default: t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int WIDTH = 69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] chain_q
);

  always_ff @(posedge clk) begin
    if (rst)
      chain_q <= '0;
    else if (shift_en)
      chain_q <= {chain_q[WIDTH-2:0], din};
  end

endmodule

// File: rtl/lut_result_sel.sv
module lut_result_sel
  import flc_pkg::*;
#(
  parameter bit RES = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  input  cell_in_t          ins,
  input  logic [TBL_W-1:0]  tbl,
  input  logic              quiet,
  output logic              comb
);

  tap_t tap;

  always_comb begin
    tap  = result_tap(code, ins, RES);
    comb = tap.hit & tbl[tap.idx] & ~quiet;
  end

endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic bypass,
  input  logic quiet,
  input  logic d,
  output logic q
);

  logic cap_q;

  always_ff @(posedge clk) begin
    if (rst)
      cap_q <= 1'b0;
    else if (ce)
      cap_q <= d;
  end

  always_comb q = quiet ? 1'b0 : (bypass ? d : cap_q);

endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
  import flc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_load,
  input  logic cfg_bit,
  input  logic ce,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  input  logic in_d,
  input  logic in_e0,
  input  logic in_f0,
  input  logic in_e1,
  input  logic in_f1,
  output logic out0,
  output logic out1
);

  localparam int CODE_LSB = NUM_RES;
  localparam int TBL_LSB  = NUM_RES + CODE_W;

  logic [CHAIN_W-1:0] chain_q;
  logic [TBL_W-1:0]   tbl_w;
  logic [CODE_W-1:0]  code_w;
  logic [NUM_RES-1:0] byp_w;
  logic [NUM_RES-1:0] comb_w;
  logic [NUM_RES-1:0] res_w;
  logic               comb0_w, comb1_w, byp0_w, byp1_w;
  cell_in_t           ins_w;

  lut_cfg_chain #(.WIDTH(CHAIN_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_en(cfg_load),
    .din     (cfg_bit),
    .chain_q (chain_q)
  );

  assign tbl_w  = chain_q[TBL_LSB +: TBL_W];
  assign code_w = chain_q[CODE_LSB +: CODE_W];
  // bit 1 of the chain tail bypasses result 0, bit 0 bypasses result 1
  assign byp_w  = {chain_q[0], chain_q[1]};
  assign ins_w  = '{in_a, in_b, in_c, in_d, in_e0, in_f0, in_e1, in_f1};

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    lut_result_sel #(.RES(g[0])) u_sel (
      .code (code_w),
      .ins  (ins_w),
      .tbl  (tbl_w),
      .quiet(cfg_load),
      .comb (comb_w[g])
    );
    lut_out_stage u_out (
      .clk   (clk),
      .rst   (rst),
      .ce    (ce),
      .bypass(byp_w[g]),
      .quiet (cfg_load),
      .d     (comb_w[g]),
      .q     (res_w[g])
    );
  end

  assign out0    = res_w[0];
  assign out1    = res_w[1];
  assign comb0_w = comb_w[0];
  assign comb1_w = comb_w[1];
  assign byp0_w  = byp_w[0];
  assign byp1_w  = byp_w[1];

endmodule

// File: rtl/flc_checker.sv
module flc_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_load,
  input logic       ce,
  input logic       in_e0,
  input logic       in_f0,
  input logic       in_e1,
  input logic       in_f1,
  input logic       out0,
  input logic       out1,
  input logic       comb0,
  input logic       comb1,
  input logic       byp0,
  input logic       byp1,
  input logic [2:0] code
);

  assert_cfg_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> (out0 == 1'b0 && out1 == 1'b0));

  assert_single_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (code == 3'd0) |-> (comb1 == 1'b0));

  assert_single_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (code == 3'd1) |-> (comb0 == 1'b0));

  assert_shared_match_R7: assert property (@(posedge clk) disable iff (rst)
    (code == 3'd5 && in_e0 == in_e1 && in_f0 == in_f1) |-> (comb0 == comb1));

  assert_bad_code_R8: assert property (@(posedge clk) disable iff (rst)
    (code[2:1] == 2'b11) |-> (comb0 == 1'b0 && comb1 == 1'b0));

  assert_bypass0_R9: assert property (@(posedge clk) disable iff (rst)
    (byp0 && !cfg_load) |-> (out0 == comb0));

  assert_bypass1_R9: assert property (@(posedge clk) disable iff (rst)
    (byp1 && !cfg_load) |-> (out1 == comb1));

  assert_capture0_R9: assert property (@(posedge clk) disable iff (rst)
    (ce && !byp0 && !cfg_load) |=> (cfg_load || out0 == $past(comb0)));

  assert_hold0_R10: assert property (@(posedge clk) disable iff (rst)
    (!ce && !byp0 && !cfg_load) |=> (cfg_load || $stable(out0)));

  assert_hold1_R10: assert property (@(posedge clk) disable iff (rst)
    (!ce && !byp1 && !cfg_load) |=> (cfg_load || $stable(out1)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (out0 == 1'b0 && out1 == 1'b0));

endmodule

bind frac_lut_cell flc_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_load(cfg_load),
  .ce      (ce),
  .in_e0   (in_e0),
  .in_f0   (in_f0),
  .in_e1   (in_e1),
  .in_f1   (in_f1),
  .out0    (out0),
  .out1    (out1),
  .comb0   (comb0_w),
  .comb1   (comb1_w),
  .byp0    (byp0_w),
  .byp1    (byp1_w),
  .code    (code_w)
);

// File: tb/sim_frac_lut_cell.sv
module sim_frac_lut_cell;

  localparam int PER = 10;
  localparam int NXB = 8;
  // {a,b,c,d,e0,f0,e1,f1,exp0,exp1}: crossbar, out = a..d selected by {f,e}
  localparam logic [9:0] XBAR_VEC [NXB] = '{
    10'b1000_00_10_10, 10'b0100_10_00_10, 10'b0010_01_11_10, 10'b0001_11_11_11,
    10'b1110_11_01_01, 10'b0111_00_10_01, 10'b1010_01_00_11, 10'b0101_01_10_01
  };
  localparam logic [63:0] MIX_TBL = 64'hC3A5_96F0_1E2D_7B48;

  logic clk = 1'b0, rst = 1'b1, cfg_load = 1'b0, cfg_bit = 1'b0, ce = 1'b0;
  logic in_a = 0, in_b = 0, in_c = 0, in_d = 0, in_e0 = 0, in_f0 = 0, in_e1 = 0, in_f1 = 0;
  logic out0, out1;
  int   n_chk = 0, n_bad = 0;

  always #(PER/2) clk = ~clk;

  frac_lut_cell u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit), .ce(ce),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .in_e0(in_e0), .in_f0(in_f0), .in_e1(in_e1), .in_f1(in_f1),
    .out0(out0), .out1(out1)
  );

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got out0/out1=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [63:0] xbar_table();
    logic [63:0] t;
    for (int i = 0; i < 64; i++) t[i] = i[i / 16];
    return t;
  endfunction

  // Bench restatement of the layouts, in integer index arithmetic.
  function automatic logic [1:0] model(input logic [63:0] t, input int code, input logic [7:0] v);
    int a, b, c, d, e0, f0, e1, f1, lo, hi;
    logic r0, r1;
    {a, b, c, d, e0, f0, e1, f1} = {31'd0, v[7], 31'd0, v[6], 31'd0, v[5], 31'd0, v[4],
                                    31'd0, v[3], 31'd0, v[2], 31'd0, v[1], 31'd0, v[0]};
    lo = a + 2*b + 4*c + 8*d;
    r0 = 0; r1 = 0;
    case (code)
      0: r0 = t[lo + 16*e0 + 32*f0];
      1: r1 = t[lo + 16*e1 + 32*f1];
      2: begin r0 = t[a + 2*b + 4*e0 + 8*f0]; r1 = t[32 + c + 2*d + 4*e1 + 8*f1]; end
      3: begin r0 = t[a + 2*b + 4*c + 8*e0 + 16*f0]; r1 = t[32 + d + 2*e1 + 4*f1]; end
      4: begin r0 = t[a + 2*b + 4*c + 8*e0 + 16*f0]; r1 = t[32 + a + 2*b + 4*d + 8*e1 + 16*f1]; end
      5: begin r0 = t[lo + 16*e0 + 32*f0]; r1 = t[lo + 16*e1 + 32*f1]; end
      default: begin hi = 0; r0 = 1'b0; r1 = 1'b0; end
    endcase
    return {r0, r1};
  endfunction

  task automatic drive(input logic [7:0] v);
    {in_a, in_b, in_c, in_d, in_e0, in_f0, in_e1, in_f1} = v;
  endtask

  // R1: table 63..0, code 2..0, bypass0, bypass1; R2 sampled during the shift
  task automatic load(input logic [63:0] t, input logic [2:0] code, input logic b0, input logic b1);
    logic [68:0] s;
    s = {t, code, b0, b1};
    for (int i = 68; i >= 0; i--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_bit  = s[i];
      if (i % 23 == 0) begin
        #(PER/4);
        check("R2 quiet while loading", {out0, out1}, 2'b00);
      end
    end
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(PER * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #(PER/4);
    check("R10 reset state", {out0, out1}, 2'b00);

    // R7 crossbar, bypassed (R9 same-cycle path)
    load(xbar_table(), 3'd5, 1'b1, 1'b1);
    for (int k = 0; k < NXB; k++) begin
      @(negedge clk);
      drive(XBAR_VEC[k][9:2]);
      #(PER/4);
      check("R7 crossbar bypassed", {out0, out1}, XBAR_VEC[k][1:0]);
    end

    // R7 crossbar, registered (R9 one edge later)
    load(xbar_table(), 3'd5, 1'b0, 1'b0);
    ce = 1'b1;
    for (int k = 0; k < NXB; k++) begin
      @(negedge clk);
      drive(XBAR_VEC[k][9:2]);
      @(posedge clk);
      #(PER/4);
      check("R9 crossbar registered", {out0, out1}, XBAR_VEC[k][1:0]);
    end

    // R3 R4 R5 R6 R8: each layout code swept against the bench model
    for (int code = 0; code < 8; code++) begin
      load(MIX_TBL, code[2:0], 1'b1, 1'b1);
      for (int k = 0; k < 24; k++) begin
        logic [7:0] v;
        v = 8'((k * 37 + code * 11 + 5) & 255);
        @(negedge clk);
        drive(v);
        #(PER/4);
        case (code)
          0, 1: check("R3 single six-input", {out0, out1}, model(MIX_TBL, code, v));
          2: check("R4 two four-input", {out0, out1}, model(MIX_TBL, code, v));
          3: check("R5 five plus three", {out0, out1}, model(MIX_TBL, code, v));
          4: check("R6 two five-input", {out0, out1}, model(MIX_TBL, code, v));
          5: check("R7 shared six-input", {out0, out1}, model(MIX_TBL, code, v));
          default: check("R8 unsupported code", {out0, out1}, 2'b00);
        endcase
      end
    end

    // R8 with an all-ones table
    load({64{1'b1}}, 3'd7, 1'b1, 1'b1);
    @(negedge clk); drive(8'hA5); #(PER/4);
    check("R8 code 7 all-ones table", {out0, out1}, 2'b00);

    // R1 shift order: single table bit 63 reached only by all-ones inputs
    load(64'h8000_0000_0000_0000, 3'd5, 1'b1, 1'b1);
    @(negedge clk); drive(8'b1111_11_11); #(PER/4);
    check("R1 table bit 63 first", {out0, out1}, 2'b11);
    @(negedge clk); drive(8'b1111_01_11); #(PER/4);
    check("R1 table bit 63 only", {out0, out1}, 2'b01);

    // R1 bypass bit order: bypass only result 0
    load(64'hFFFF_FFFF_FFFF_FFFF, 3'd5, 1'b1, 1'b0);
    ce = 1'b0;
    @(negedge clk); drive(8'h00); #(PER/4);
    check("R1 bypass0 then bypass1", {out0, out1}, 2'b10);

    // R10 ce low holds, then sync reset clears
    load(xbar_table(), 3'd5, 1'b0, 1'b0);
    ce = 1'b1;
    @(negedge clk); drive(8'b1000_00_00);
    @(posedge clk); #(PER/4);
    check("R10 captured before hold", {out0, out1}, 2'b11);
    @(negedge clk); ce = 1'b0; drive(8'b0000_00_00);
    @(posedge clk); #(PER/4);
    check("R10 ce low holds", {out0, out1}, 2'b11);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #(PER/4);
    check("R10 sync reset clears", {out0, out1}, 2'b00);
    @(negedge clk); rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule